// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block lets a host processor read and write the settings and status of a connector-orientation controller over a standard I2C bus. It runs on the system clock and oversamples SCL and SDA. It works out bus events from their edges and pulls SDA low whenever it acknowledges or sends a zero bit. A three-level strap picks the bus address, or turns the target off so that the pins can serve as plain outputs. The block acknowledges nothing until a wake-up interval has passed after reset or enable.

The block keeps its own copies of the status fields. The detection logic loads them with a one-cycle change strobe, and each load raises an interrupt flag. The flag drives an active-low open-drain request line and stays set until the host writes a one to it. The block also holds the configuration fields that the detection logic consumes. A control bit starts a self-timed soft reset, during which the status copies are held at zero and an output tells the detection logic to restart and resample its mode strap. Offsets 0x00 to 0x07 return a fixed identification string.

A read that follows the setting of a sub-address starts at that sub-address. Any other read starts at offset 0. The offset then advances by one for each byte.

Top module: `cfg_i2c_target`

## Requirements
- R1: The address strap `addr_strap` = 2'b10 selects 7-bit address 0x67 and 2'b01 selects 0x47. Codes 2'b00 and 2'b11 disable the target, so no address is acknowledged. An acknowledge is SDA held low during the ninth clock of the address byte.
- R2: After reset, or after `enable` goes high, no address is acknowledged until WAKE_CYCLES clock cycles have passed. After that, a matching address is acknowledged.
- R3: A read that is not preceded by a sub-address-only write starts at offset 0x00. Offsets 0x00 to 0x07 return 0x30, 0x32, 0x33, 0x42, 0x53, 0x55, 0x54, 0x00 in that order.
- R4: The first data byte of a write transaction sets the sub-address. If the transaction ends (STOP or repeated START) with no further byte, the next read starts there. Reads advance the offset by one per byte, and a data write disarms the sub-address.
- R5: Each data byte after the sub-address writes the current offset, and the offset then advances by one. All writable fields reset to zero.
- R6: The current register (0x08) holds advertised current in [7:6] (read/write), detected current in [5:4], accessory code in [3:1] and active cable in [0]. The attach register (0x09) holds attach state in [7:6], cable direction in [5], interrupt flag in [4] and a reserved zero in [3]; duty-cycle select [2:1] and UFP-accessory disable [0] are read/write. The control register (0x0A) holds debounce [7:6], mode [5:4], soft-reset [3], source preference [2:1] and termination disable [0]. Offset 0x0B reads 0x02. Read-only, reserved and unmapped locations ignore writes, and unmapped offsets read 0.
- R7: A `stat_upd` pulse loads detected current, accessory, active cable, attach state and cable direction into the registers, sets the interrupt flag and drives `int_pull` high.
- R8: Writing 0x09 with bit 4 set clears the interrupt flag and releases `int_pull`. With bit 4 clear, the flag is unchanged.
- R9: Writing 0x0A with bit 3 set holds `soft_rst` and the read-back bit 3 high for SRST_CYCLES cycles, after which both clear. During that time the status copies read zero and `stat_upd` is ignored. Configuration fields and the interrupt flag keep their values.
- R10: START and repeated START are taken from SDA falling while SCL is high, and STOP from SDA rising while SCL is high. A master NACK ends a read. A repeated START may switch a transaction from write to read.
- R11: While `enable` is low, the block is held in reset. All configuration outputs, `int_pull` and `sda_pull` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low holds reset |
| addr_strap | input | 2 | Three-level address strap code |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired) |
| det_cur | input | 2 | Detected current mode from detection logic |
| acc_code | input | 3 | Accessory code from detection logic |
| act_cable | input | 1 | Active cable seen |
| att_state | input | 2 | Attach state |
| cable_dir | input | 1 | Cable direction |
| stat_upd | input | 1 | One-cycle status-change strobe |
| adv_cur | output | 2 | Advertised current setting |
| duty_sel | output | 2 | Dual-role duty-cycle setting |
| ufp_acc_off | output | 1 | Disable accessory detect as sink |
| debounce_sel | output | 2 | Debounce time setting |
| mode_sel | output | 2 | Port mode override |
| src_pref | output | 2 | Dual-role preference |
| term_off | output | 1 | Termination disable |
| soft_rst | output | 1 | Soft reset in progress |
| sda_pull | output | 1 | Pull SDA low |
| int_pull | output | 1 | Pull interrupt line low |

## Verification
The bench sets WAKE_CYCLES to 1000 and SRST_CYCLES to 4000 instead of the millisecond-scale defaults. With these values the wake-up refusal and the whole soft-reset window fit within a few bus transactions. It can then check that the soft-reset bit reads as one, that strobes are ignored during the window, and that the bit clears afterwards. The two-stage synchronizer and a bus quarter-period of eight clocks leave a clear margin between the target's SDA changes and the master's sampling points. Random write, strobe and read sequences then cover all sixteen low offsets, including the wrap past the mapped range.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK
  } bus_st_t;

  localparam logic [7:0] OFF_CUR = 8'h08;
  localparam logic [7:0] OFF_ATT = 8'h09;
  localparam logic [7:0] OFF_CTL = 8'h0A;
  localparam logic [7:0] OFF_REV = 8'h0B;
  localparam logic [7:0] REV_VAL = 8'h02;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h30;
      3'd1: id_byte = 8'h32;
      3'd2: id_byte = 8'h33;
      3'd3: id_byte = 8'h42;
      3'd4: id_byte = 8'h53;
      3'd5: id_byte = 8'h55;
      3'd6: id_byte = 8'h54;
      default: id_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfg_i2c_edges.sv
module cfg_i2c_edges #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_p  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_p   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/cfg_i2c_fsm.sv
module cfg_i2c_fsm
  import cfg_i2c_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ready,
  input  logic          addr_ok,
  input  logic [6:0]    my_addr,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          sda_pull
);
  bus_st_t     st;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg, tx;
  logic [AW-1:0] ptr;
  logic        rnw, first, armed, nack;
  logic        hit;

  assign hit     = ready && addr_ok && (shreg[7:1] == my_addr);
  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0; ptr <= '0;
      rnw <= 1'b0; first <= 1'b0; armed <= 1'b0; nack <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; sda_pull <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_p) begin
        st <= S_IDLE; sda_pull <= 1'b0;
      end else if (start_p) begin
        st <= S_ADDR; bitcnt <= '0; sda_pull <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s}; bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (hit) begin
                st <= S_AACK; sda_pull <= 1'b1; rnw <= shreg[0]; first <= 1'b1;
                if (shreg[0]) begin
                  if (!armed) ptr <= '0;
                  armed <= 1'b0;
                end
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rnw) begin
              st <= S_RD; tx <= rd_data; sda_pull <= ~rd_data[7];
            end else begin
              st <= S_WR; sda_pull <= 1'b0;
            end
          end
          S_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s}; bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              st <= S_WACK; sda_pull <= 1'b1;
              if (first) begin
                ptr <= shreg[AW-1:0]; armed <= 1'b1; first <= 1'b0;
              end else begin
                wr_en <= 1'b1; wr_addr <= ptr; wr_data <= shreg;
                ptr <= ptr + 1'b1; armed <= 1'b0;
              end
            end
          end
          S_WACK: if (scl_fall) begin
            st <= S_WR; sda_pull <= 1'b0; bitcnt <= '0;
          end
          S_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                st <= S_RACK; sda_pull <= 1'b0; ptr <= ptr + 1'b1;
              end else begin
                sda_pull <= ~tx[6]; tx <= {tx[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (scl_rise) nack <= sda_s;
            else if (scl_fall) begin
              if (nack) st <= S_IDLE;
              else begin
                st <= S_RD; bitcnt <= '0; tx <= rd_data; sda_pull <= ~rd_data[7];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  wake_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !sda_pull);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_p || start_p) |=> !sda_pull);
  // R5
  wr_origin_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(st == S_WR));
endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs
  import cfg_i2c_pkg::*;
#(
  parameter int AW          = 8,
  parameter int SRST_CYCLES = 12_250_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic [1:0]    det_cur,
  input  logic [2:0]    acc_code,
  input  logic          act_cable,
  input  logic [1:0]    att_state,
  input  logic          cable_dir,
  input  logic          stat_upd,
  output logic [1:0]    adv_cur,
  output logic [1:0]    duty_sel,
  output logic          ufp_acc_off,
  output logic [1:0]    debounce_sel,
  output logic [1:0]    mode_sel,
  output logic [1:0]    src_pref,
  output logic          term_off,
  output logic          soft_rst,
  output logic          int_pull
);
  localparam int CW = $clog2(SRST_CYCLES + 1);

  logic [1:0] det_q, att_q;
  logic [2:0] acc_q;
  logic       cab_q, dir_q;
  logic [CW-1:0] srst_cnt;
  logic       w_cur, w_att, w_ctl;

  assign w_cur = wr_en && wr_addr == OFF_CUR[AW-1:0];
  assign w_att = wr_en && wr_addr == OFF_ATT[AW-1:0];
  assign w_ctl = wr_en && wr_addr == OFF_CTL[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      adv_cur <= '0; duty_sel <= '0; ufp_acc_off <= 1'b0;
      debounce_sel <= '0; mode_sel <= '0; src_pref <= '0; term_off <= 1'b0;
    end else begin
      if (w_cur) adv_cur <= wr_data[7:6];
      if (w_att) begin
        duty_sel <= wr_data[2:1]; ufp_acc_off <= wr_data[0];
      end
      if (w_ctl) begin
        debounce_sel <= wr_data[7:6]; mode_sel <= wr_data[5:4];
        src_pref <= wr_data[2:1]; term_off <= wr_data[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_rst <= 1'b0; srst_cnt <= '0;
    end else if (soft_rst) begin
      srst_cnt <= srst_cnt - 1'b1;
      if (srst_cnt == CW'(1)) soft_rst <= 1'b0;
    end else if (w_ctl && wr_data[3]) begin
      soft_rst <= 1'b1; srst_cnt <= CW'(SRST_CYCLES);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      det_q <= '0; acc_q <= '0; cab_q <= 1'b0; att_q <= '0; dir_q <= 1'b0;
    end else if (stat_upd) begin
      det_q <= det_cur; acc_q <= acc_code; cab_q <= act_cable;
      att_q <= att_state; dir_q <= cable_dir;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) int_pull <= 1'b0;
    else if (stat_upd && !soft_rst) int_pull <= 1'b1;
    else if (w_att && wr_data[4]) int_pull <= 1'b0;
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr < AW'(8)) rd_data = id_byte(rd_addr[2:0]);
    else if (rd_addr == OFF_CUR[AW-1:0]) rd_data = {adv_cur, det_q, acc_q, cab_q};
    else if (rd_addr == OFF_ATT[AW-1:0]) rd_data = {att_q, dir_q, int_pull, 1'b0, duty_sel, ufp_acc_off};
    else if (rd_addr == OFF_CTL[AW-1:0]) rd_data = {debounce_sel, mode_sel, soft_rst, src_pref, term_off};
    else if (rd_addr == OFF_REV[AW-1:0]) rd_data = REV_VAL;
  end

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_upd && !soft_rst) |=> int_pull);
  // R9
  srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (det_q == 2'b0 && acc_q == 3'b0 && !cab_q && att_q == 2'b0 && !dir_q));
  // R9
  srst_hold_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !wr_en) |=> $stable(mode_sel));
endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int WAKE_CYCLES = 25_000_000,
  parameter int SRST_CYCLES = 12_250_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic [1:0] addr_strap,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] det_cur,
  input  logic [2:0] acc_code,
  input  logic       act_cable,
  input  logic [1:0] att_state,
  input  logic       cable_dir,
  input  logic       stat_upd,
  output logic [1:0] adv_cur,
  output logic [1:0] duty_sel,
  output logic       ufp_acc_off,
  output logic [1:0] debounce_sel,
  output logic [1:0] mode_sel,
  output logic [1:0] src_pref,
  output logic       term_off,
  output logic       soft_rst,
  output logic       sda_pull,
  output logic       int_pull
);
  localparam int WW = $clog2(WAKE_CYCLES + 1);

  logic          blk_rst, ready, addr_ok;
  logic [WW-1:0] wake_cnt;
  logic [6:0]    my_addr;
  logic          sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic [7:0]    rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          wr_en;

  assign blk_rst = rst | ~enable;

  always_ff @(posedge clk) begin
    if (blk_rst) begin
      wake_cnt <= '0; ready <= 1'b0;
    end else if (!ready) begin
      wake_cnt <= wake_cnt + 1'b1;
      if (wake_cnt == WW'(WAKE_CYCLES - 1)) ready <= 1'b1;
    end
  end

  always_comb begin
    addr_ok = 1'b1;
    case (addr_strap)
      2'b10:   my_addr = 7'h67;
      2'b01:   my_addr = 7'h47;
      default: begin my_addr = 7'h00; addr_ok = 1'b0; end
    endcase
  end

  cfg_i2c_edges #(.STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst(blk_rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p));

  cfg_i2c_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst(blk_rst), .ready(ready), .addr_ok(addr_ok), .my_addr(my_addr),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall), .start_p(start_p),
    .stop_p(stop_p), .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_pull(sda_pull));

  cfg_i2c_regs #(.AW(AW), .SRST_CYCLES(SRST_CYCLES)) u_regs (
    .clk(clk), .rst(blk_rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .det_cur(det_cur), .acc_code(acc_code),
    .act_cable(act_cable), .att_state(att_state), .cable_dir(cable_dir),
    .stat_upd(stat_upd), .adv_cur(adv_cur), .duty_sel(duty_sel),
    .ufp_acc_off(ufp_acc_off), .debounce_sel(debounce_sel), .mode_sel(mode_sel),
    .src_pref(src_pref), .term_off(term_off), .soft_rst(soft_rst), .int_pull(int_pull));

  // R11
  disabled_quiet_chk: assert property (@(posedge clk)
    !enable |=> (!sda_pull && !int_pull && mode_sel == 2'b0));
endmodule

// File: tb/cfg_i2c_target_bench.sv
module cfg_i2c_target_bench;
  localparam int Q = 8;
  localparam int WAKE = 1000;
  localparam int SRST = 4000;

  logic clk = 1'b0;
  logic rst = 1'b1, enable = 1'b1;
  logic [1:0] addr_strap = 2'b10;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [1:0] det_cur = '0, att_state = '0;
  logic [2:0] acc_code = '0;
  logic act_cable = 1'b0, cable_dir = 1'b0, stat_upd = 1'b0;
  logic [1:0] adv_cur, duty_sel, debounce_sel, mode_sel, src_pref;
  logic ufp_acc_off, term_off, soft_rst, sda_pull, int_pull;
  wire  sda_line = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0;
  logic [7:0] rbuf [0:15];
  logic [6:0] dev = 7'h67;
  logic ack;

  logic [1:0] m_adv, m_det, m_att, m_duty, m_deb, m_mode, m_pref;
  logic [2:0] m_acc;
  logic m_cab, m_dir, m_irq, m_dufp, m_term, m_srst;

  always #2 clk = ~clk;

  cfg_i2c_target #(.WAKE_CYCLES(WAKE), .SRST_CYCLES(SRST)) u_cfg_i2c_target (
    .clk(clk), .rst(rst), .enable(enable), .addr_strap(addr_strap), .scl_i(scl),
    .sda_i(sda_line), .det_cur(det_cur), .acc_code(acc_code), .act_cable(act_cable),
    .att_state(att_state), .cable_dir(cable_dir), .stat_upd(stat_upd),
    .adv_cur(adv_cur), .duty_sel(duty_sel), .ufp_acc_off(ufp_acc_off),
    .debounce_sel(debounce_sel), .mode_sel(mode_sel), .src_pref(src_pref),
    .term_off(term_off), .soft_rst(soft_rst), .sda_pull(sda_pull), .int_pull(int_pull));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic m_reset();
    m_adv = 0; m_det = 0; m_att = 0; m_duty = 0; m_deb = 0; m_mode = 0; m_pref = 0;
    m_acc = 0; m_cab = 0; m_dir = 0; m_irq = 0; m_dufp = 0; m_term = 0; m_srst = 0;
  endtask

  function automatic logic [7:0] exp_reg(input logic [7:0] off);
    case (off)
      8'h00: return 8'h30;  8'h01: return 8'h32;  8'h02: return 8'h33;
      8'h03: return 8'h42;  8'h04: return 8'h53;  8'h05: return 8'h55;
      8'h06: return 8'h54;  8'h07: return 8'h00;
      8'h08: return {m_adv, m_det, m_acc, m_cab};
      8'h09: return {m_att, m_dir, m_irq, 1'b0, m_duty, m_dufp};
      8'h0A: return {m_deb, m_mode, m_srst, m_pref, m_term};
      8'h0B: return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(input logic [7:0] off, input logic [7:0] d);
    case (off)
      8'h08: m_adv = d[7:6];
      8'h09: begin if (d[4]) m_irq = 0; m_duty = d[2:1]; m_dufp = d[0]; end
      8'h0A: begin m_deb = d[7:6]; m_mode = d[5:4]; m_pref = d[2:1]; m_term = d[0]; end
      default: ;
    endcase
  endtask

  task automatic b_start(); sda_m = 1; cyc(Q); scl = 1; cyc(Q); sda_m = 0; cyc(Q); scl = 0; cyc(Q); endtask
  task automatic b_stop();  sda_m = 0; cyc(Q); scl = 1; cyc(Q); sda_m = 1; cyc(Q); endtask
  task automatic wbit(input logic b); sda_m = b; cyc(Q); scl = 1; cyc(2*Q); scl = 0; cyc(Q); endtask
  task automatic rbit(output logic b); sda_m = 1; cyc(Q); scl = 1; cyc(Q); b = sda_line; cyc(Q); scl = 0; cyc(Q); endtask

  task automatic wbyte(input logic [7:0] d, output logic a);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b); a = ~b;
  endtask

  task automatic rbyte(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(last);
  endtask

  task automatic reg_write(input logic [7:0] off, input logic [7:0] d);
    logic a;
    b_start(); wbyte({dev, 1'b0}, a); wbyte(off, a); wbyte(d, a); b_stop();
    m_write(off, d);
  endtask

  task automatic set_sub(input logic [7:0] off);
    logic a;
    b_start(); wbyte({dev, 1'b0}, a); wbyte(off, a); b_stop();
  endtask

  task automatic reg_read(input bit use_sub, input logic [7:0] off, input int n);
    logic a;
    b_start();
    if (use_sub) begin wbyte({dev, 1'b0}, a); wbyte(off, a); b_start(); end
    wbyte({dev, 1'b1}, a);
    for (int i = 0; i < n; i++) rbyte(i == n - 1, rbuf[i]);
    b_stop();
  endtask

  task automatic check_read(input logic [7:0] base, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = exp_reg(base + 8'(i));
      chk(rbuf[i] == e, req, rbuf[i], e);
    end
  endtask

  task automatic strobe(input logic [1:0] d, input logic [2:0] a, input logic c,
                        input logic [1:0] t, input logic r);
    det_cur = d; acc_code = a; act_cable = c; att_state = t; cable_dir = r;
    stat_upd = 1; cyc(1); stat_upd = 0; cyc(2);
    if (!m_srst) begin
      m_det = d; m_acc = a; m_cab = c; m_att = t; m_dir = r; m_irq = 1;
    end
  endtask

  task automatic addr_probe(input logic [6:0] a7, output logic a);
    b_start(); wbyte({a7, 1'b0}, a); b_stop();
  endtask

  initial begin
    cyc(30_000_0 / 2);
    $display("FAIL watchdog actual=0 expected=1");
    n_fail++; n_chk++;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic a;
    void'($urandom(32'h5eed_1234));
    m_reset();
    cyc(5); rst = 0; cyc(1);
    // R11 reset state
    chk(adv_cur == 0 && mode_sel == 0 && int_pull == 0 && sda_pull == 0, "R11 reset", adv_cur, 0);
    // R2 early access refused
    addr_probe(7'h67, a);
    chk(a == 0, "R2 early nack", a, 0);
    cyc(WAKE);
    addr_probe(7'h67, a);
    chk(a == 1, "R2 ack after wake", a, 1);
    // R1 strap variants
    addr_strap = 2'b01; addr_probe(7'h67, a); chk(a == 0, "R1 low strap rejects 0x67", a, 0);
    addr_probe(7'h47, a); chk(a == 1, "R1 low strap 0x47", a, 1);
    addr_strap = 2'b00; addr_probe(7'h47, a); chk(a == 0, "R1 float strap", a, 0);
    addr_strap = 2'b11; addr_probe(7'h67, a); chk(a == 0, "R1 code 11 disabled", a, 0);
    addr_strap = 2'b10;
    // R3 read from offset 0 without sub-address
    reg_read(0, 8'h00, 12); check_read(8'h00, 12, "R3 id from zero");
    // R4 sub-address only then plain read, auto increment
    set_sub(8'h06); reg_read(0, 8'h00, 5); check_read(8'h06, 5, "R4 armed read");
    reg_read(0, 8'h00, 2); check_read(8'h00, 2, "R4 disarmed after read");
    // R10 repeated start read
    reg_read(1, 8'h0B, 2); check_read(8'h0B, 2, "R10 repeated start");
    // R5 burst write with increment
    b_start(); wbyte({dev, 1'b0}, a); wbyte(8'h09, a);
    wbyte(8'h05, a); m_write(8'h09, 8'h05); wbyte(8'hE7, a); m_write(8'h0A, 8'hE7); b_stop();
    chk(duty_sel == 2'b10 && ufp_acc_off == 1, "R5 burst 0x09", {duty_sel, ufp_acc_off}, 3'b101);
    chk(debounce_sel == 3 && mode_sel == 2 && src_pref == 3 && term_off == 1, "R5 burst 0x0A",
        {debounce_sel, mode_sel, src_pref, term_off}, 7'b1110111);
    reg_read(0, 8'h00, 2); check_read(8'h00, 2, "R4 data write disarms");
    // R6 read-only and reserved ignored
    reg_write(8'h08, 8'hBF); reg_write(8'h02, 8'hFF); reg_write(8'h0B, 8'h77);
    reg_read(1, 8'h00, 12); check_read(8'h00, 12, "R6 ignored writes");
    chk(adv_cur == 2'b10, "R6 adv field", adv_cur, 2);
    // R7 strobe sets irq
    strobe(2'b11, 3'b101, 1, 2'b01, 1);
    chk(int_pull == 1, "R7 int_pull set", int_pull, 1);
    reg_read(1, 8'h08, 2); check_read(8'h08, 2, "R7 captured");
    // R8 write zero no effect, one clears
    reg_write(8'h09, 8'h00);
    chk(int_pull == 1, "R8 zero write keeps", int_pull, 1);
    reg_write(8'h09, 8'h10);
    chk(int_pull == 0, "R8 one clears", int_pull, 0);
    // R9 soft reset
    strobe(2'b01, 3'b100, 1, 2'b10, 0);
    reg_write(8'h09, 8'h10);
    reg_write(8'h0A, 8'h28); m_srst = 1;
    chk(soft_rst == 1, "R9 soft_rst high", soft_rst, 1);
    m_det = 0; m_acc = 0; m_cab = 0; m_att = 0; m_dir = 0;
    strobe(2'b11, 3'b111, 1, 2'b11, 1);
    chk(int_pull == 0, "R9 strobe ignored", int_pull, 0);
    reg_read(1, 8'h08, 3); check_read(8'h08, 3, "R9 during reset");
    cyc(SRST); m_srst = 0;
    chk(soft_rst == 0, "R9 self clear", soft_rst, 0);
    reg_read(1, 8'h08, 3); check_read(8'h08, 3, "R9 after reset");
    // random mix
    for (int it = 0; it < 40; it++) begin
      int k;
      k = $urandom % 3;
      if (k == 0) begin
        logic [7:0] off, d;
        off = 8'($urandom % 16); d = 8'($urandom);
        if (off == 8'h0A) d[3] = 0;
        reg_write(off, d);
      end else if (k == 1) begin
        strobe(2'($urandom), 3'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
      end else begin
        logic [7:0] base; int n;
        base = 8'($urandom % 16); n = 1 + $urandom % 4;
        reg_read(1, base, n); check_read(base, n, "R5 R6 random read");
      end
      chk(int_pull == m_irq, "R7 R8 random irq", int_pull, m_irq);
    end
    // R11 enable low
    reg_write(8'h0A, 8'h31); strobe(1, 1, 1, 1, 1);
    enable = 0; cyc(3);
    chk(mode_sel == 0 && term_off == 0 && int_pull == 0 && sda_pull == 0, "R11 disabled",
        {mode_sel, term_off, int_pull}, 0);
    enable = 1; cyc(1); m_reset();
    addr_probe(7'h67, a); chk(a == 0, "R2 R11 wake after enable", a, 0);
    cyc(WAKE);
    reg_read(1, 8'h08, 3); check_read(8'h08, 3, "R11 cleared regs");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule